// File: doc/BRIEF.md
# Power-to-Pulse Frequency Generator

This block converts a stream of signed real-power samples into pulse trains whose rate follows the delivered energy. Every valid sample adds its magnitude to two independent unsigned energy buckets. The slow bucket drives a pair of active-low outputs that take turns, so together they can step a two-phase counter motor. The fast bucket drives an active-high calibration output whose rate is a selectable multiple of the slow rate. A direction flag reports whether net power over the most recent slow interval was negative.

Each time a bucket reaches its threshold it emits one event and keeps the excess, so no energy is lost between pulses. Pulse widths are parameters counted in clock cycles. When an output's own period becomes too short for its nominal width, the width drops to half the period, giving a square wave. Timing parameters can be scaled down so that short simulations still cover every behaviour.

Top module: `pwr_pulse_gen`

## Requirements
- R1: While `smp_vld` is high, the absolute value of `smp_pwr` (two's complement) is added to the slow bucket. When the sum reaches or exceeds `BASE_TH >> rate_sel` (`rate_sel` 0..3), one slow event occurs and the bucket keeps the sum minus the threshold.
- R2: Slow events drive F1 and F2 in turn, and the first event after reset goes to F1. The chosen output goes low at the same clock edge that samples the triggering input.
- R3: An active pulse lasts `F_WIDTH` cycles on F1/F2 or `CF_WIDTH` cycles on CF. This applies to the first pulse after reset and whenever the output's own trigger-to-trigger period is at least twice that width. Otherwise the pulse lasts half the period, rounded down, and never less than one cycle.
- R4: The calibration bucket accumulates the same magnitudes against the slow threshold shifted right by `CF_SH_HI` when `cal_sel`=1, or by `CF_SH_LO` when `cal_sel`=0. Each crossing raises `cf` at that edge.
- R5: At each slow event, `rev_flag` takes the value (signed sum of valid samples since the previous slow event, current sample included) < 0. Between slow events it holds its value.
- R6: Samples with `smp_vld` low have no effect on either bucket, on the signed sum or on the outputs.
- R7: A clock edge with `rst_n` low clears both buckets, the signed sum, the F1/F2 turn and all pulse timers. After that edge `f1_n`=`f2_n`=1 and `cf`=`rev_flag`=0.
- R8: Each F2 pulse starts one slow-event interval after the F1 pulse before it, which is half of F1's period.

Sample magnitudes are assumed to stay below the calibration threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Qualifies `smp_pwr` in this cycle |
| smp_pwr | input | PW | Signed real-power sample |
| rate_sel | input | 2 | Slow threshold shift (0 = lowest rate) |
| cal_sel | input | 1 | Selects the calibration rate multiple |
| f1_n | output | 1 | Stepper phase A pulse, active low |
| f2_n | output | 1 | Stepper phase B pulse, active low |
| cf | output | 1 | Calibration pulse, active high |
| rev_flag | output | 1 | Net power negative over last slow interval |

## Verification
The hardest state to reach from the ports is the width fallback. It only appears once an output has seen two of its own triggers closer together than twice the nominal width, and the first pulse after reset always keeps full width. The bench therefore uses small width parameters and constant sample values whose thresholds divide evenly. This lets it run long enough for several periods to settle before comparing the first and the last measured width. Energy carry-over is covered with a sample value that does not divide the threshold, and the pulse count is compared with the floor of total energy over threshold.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic {
    PH_F1 = 1'b0,
    PH_F2 = 1'b1
  } ppg_phase_e;

  // Pulse length from cycles since the previous trigger.
  // A saturated counter means no earlier trigger: keep the nominal width.
  function automatic word_t pulse_len(word_t since, word_t sat, word_t nom);
    word_t per;
    if (since == sat) return nom;
    per = since + 32'd1;
    if (per >= (nom << 1)) return nom;
    if (per < 32'd2) return 32'd1;
    return per >> 1;
  endfunction

endpackage

// File: rtl/ppg_accum.sv
module ppg_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic [ACC_W-1:0] mag,
  input  logic [ACC_W-1:0] thr,
  output logic             tick
);

  localparam int unsigned EXT_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [EXT_W-1:0] sum_ext;
  logic             reach;

  assign sum_ext = {1'b0, acc_q} + {1'b0, mag};
  assign reach   = vld && (sum_ext >= {1'b0, thr});
  assign tick    = reach;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (reach) begin
      acc_q <= ACC_W'(sum_ext - {1'b0, thr});
    end else if (vld) begin
      acc_q <= ACC_W'(sum_ext);
    end
  end

endmodule

// File: rtl/ppg_shaper.sv
module ppg_shaper
  import ppg_pkg::*;
#(
  parameter int unsigned NOM = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);

  localparam int unsigned CNT_W = $clog2(2 * NOM + 2) + 1;
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] since_q;
  logic [CNT_W-1:0] rem_q;
  word_t            len_w;

  assign len_w  = pulse_len(word_t'(since_q), word_t'(SAT), word_t'(NOM));
  assign active = (rem_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= SAT;
      rem_q   <= '0;
    end else if (trig) begin
      since_q <= '0;
      rem_q   <= CNT_W'(len_w);
    end else begin
      if (since_q != SAT) since_q <= since_q + CNT_W'(1);
      if (rem_q != '0)    rem_q   <= rem_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/ppg_sign_track.sv
module ppg_sign_track #(
  parameter int unsigned PW    = 16,
  parameter int unsigned SUM_W = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [PW-1:0] smp,
  input  logic          tick,
  output logic          neg
);

  logic signed [SUM_W-1:0] sum_q;
  logic signed [SUM_W-1:0] smp_x;
  logic signed [SUM_W-1:0] sum_d;

  assign smp_x = {{(SUM_W-PW){smp[PW-1]}}, smp};
  assign sum_d = sum_q + smp_x;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      neg   <= 1'b0;
    end else if (tick) begin
      sum_q <= '0;
      neg   <= sum_d[SUM_W-1];
    end else if (vld) begin
      sum_q <= sum_d;
    end
  end

endmodule

// File: rtl/pwr_pulse_gen.sv
module pwr_pulse_gen
  import ppg_pkg::*;
#(
  parameter int unsigned PW       = 16,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned BASE_TH  = 1048576,
  parameter int unsigned F_WIDTH  = 100000,
  parameter int unsigned CF_WIDTH = 32000,
  parameter int unsigned CF_SH_LO = 4,
  parameter int unsigned CF_SH_HI = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [PW-1:0] smp_pwr,
  input  logic [1:0]    rate_sel,
  input  logic          cal_sel,
  output logic          f1_n,
  output logic          f2_n,
  output logic          cf,
  output logic          rev_flag
);

  localparam int unsigned NCH   = 2;
  localparam int unsigned NOUT  = 3;
  localparam int unsigned SUM_W = ACC_W + 1;

  function automatic logic [ACC_W-1:0] abs_ext(logic [PW-1:0] v);
    logic [ACC_W-1:0] sx;
    sx = {{(ACC_W-PW){v[PW-1]}}, v};
    return sx[ACC_W-1] ? (~sx + ACC_W'(1)) : sx;
  endfunction

  function automatic logic [ACC_W-1:0] slow_thr_of(logic [1:0] sel);
    return ACC_W'(BASE_TH) >> sel;
  endfunction

  function automatic logic [ACC_W-1:0] cal_thr_of(logic [ACC_W-1:0] base, logic hi);
    return hi ? (base >> CF_SH_HI) : (base >> CF_SH_LO);
  endfunction

  // Named internal events, observed by the bound checker.
  logic             slow_tick;
  logic             cf_tick;
  logic             f1_trig;
  logic             f2_trig;
  logic [ACC_W-1:0] mag;
  logic [ACC_W-1:0] slow_thr;
  logic [ACC_W-1:0] chan_thr [NCH];
  logic [NCH-1:0]   chan_tick;
  logic [NOUT-1:0]  trig_vec;
  logic [NOUT-1:0]  act_vec;
  ppg_phase_e       phase_q;

  assign mag         = abs_ext(smp_pwr);
  assign slow_thr    = slow_thr_of(rate_sel);
  assign chan_thr[0] = slow_thr;
  assign chan_thr[1] = cal_thr_of(slow_thr, cal_sel);

  genvar gi;
  for (gi = 0; gi < NCH; gi++) begin : g_acc
    ppg_accum #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (smp_vld),
      .mag   (mag),
      .thr   (chan_thr[gi]),
      .tick  (chan_tick[gi])
    );
  end

  assign slow_tick = chan_tick[0];
  assign cf_tick   = chan_tick[1];
  assign f1_trig   = slow_tick && (phase_q == PH_F1);
  assign f2_trig   = slow_tick && (phase_q == PH_F2);
  assign trig_vec  = {cf_tick, f2_trig, f1_trig};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_F1;
    end else if (slow_tick) begin
      phase_q <= (phase_q == PH_F1) ? PH_F2 : PH_F1;
    end
  end

  for (gi = 0; gi < NOUT; gi++) begin : g_shp
    localparam int unsigned NOM = (gi == NOUT - 1) ? CF_WIDTH : F_WIDTH;
    ppg_shaper #(.NOM(NOM)) u_shp (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (trig_vec[gi]),
      .active (act_vec[gi])
    );
  end

  ppg_sign_track #(.PW(PW), .SUM_W(SUM_W)) u_sign (
    .clk   (clk),
    .rst_n (rst_n),
    .vld   (smp_vld),
    .smp   (smp_pwr),
    .tick  (slow_tick),
    .neg   (rev_flag)
  );

  assign f1_n = ~act_vec[0];
  assign f2_n = ~act_vec[1];
  assign cf   = act_vec[2];

endmodule

// File: rtl/ppg_checker.sv
module ppg_checker (
  input logic clk,
  input logic rst_n,
  input logic smp_vld,
  input logic slow_tick,
  input logic cf_tick,
  input logic f1_trig,
  input logic f2_trig,
  input logic f1_n,
  input logic f2_n,
  input logic cf,
  input logic rev_flag
);

  p_quiet_in_reset_r7: assert property (@(posedge clk)
    !rst_n |=> (f1_n && f2_n && !cf && !rev_flag));

  p_ignore_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |-> (!slow_tick && !cf_tick));

  p_f1_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    f1_trig |=> !f1_n);

  p_f2_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    f2_trig |=> !f2_n);

  p_cf_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cf_tick |=> cf);

  p_rev_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> $stable(rev_flag));

endmodule

bind pwr_pulse_gen ppg_checker u_ppg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .slow_tick (slow_tick),
  .cf_tick   (cf_tick),
  .f1_trig   (f1_trig),
  .f2_trig   (f2_trig),
  .f1_n      (f1_n),
  .f2_n      (f2_n),
  .cf        (cf),
  .rev_flag  (rev_flag)
);

// File: tb/pwr_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module pwr_pulse_gen_tb_top;

  localparam int unsigned PW = 16;
  localparam int unsigned TH = 1024;
  localparam int unsigned FW = 20;
  localparam int unsigned CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [PW-1:0] smp_pwr = '0;
  logic [1:0]    rate_sel = 2'd0;
  logic          cal_sel = 1'b0;
  logic          f1_n, f2_n, cf, rev_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pwr_pulse_gen #(
    .PW(PW), .ACC_W(32), .BASE_TH(TH), .F_WIDTH(FW), .CF_WIDTH(CW),
    .CF_SH_LO(2), .CF_SH_HI(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_pwr(smp_pwr),
    .rate_sel(rate_sel), .cal_sel(cal_sel),
    .f1_n(f1_n), .f2_n(f2_n), .cf(cf), .rev_flag(rev_flag)
  );

  // Pulse monitor: index 0 = F1, 1 = F2, 2 = CF.
  logic [2:0] act;
  logic [2:0] prev = '0;
  logic       mon_clr = 1'b0;
  int cyc = 0;
  int starts [3];
  int run    [3];
  int lastw  [3];
  int firstw [3];
  int tstart [3];

  assign act = {cf, ~f2_n, ~f1_n};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 3; i++) begin
      if (mon_clr) begin
        starts[i] = 0; run[i] = 0; lastw[i] = 0; firstw[i] = 0; tstart[i] = 0;
        prev[i] = 1'b0;
      end else begin
        if (act[i] && !prev[i]) begin
          starts[i] = starts[i] + 1; tstart[i] = cyc; run[i] = 1;
        end else if (act[i]) begin
          run[i] = run[i] + 1;
        end else if (prev[i]) begin
          lastw[i] = run[i];
          if (firstw[i] == 0) firstw[i] = run[i];
        end
        prev[i] = act[i];
      end
    end
  end

  task automatic check(string req, int actual, int expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_vld = 1'b0; smp_pwr = '0; mon_clr = 1'b1;
    repeat (3) step();
    rst_n = 1'b1; mon_clr = 1'b0;
  endtask

  task automatic run_const(int p, int n);
    for (int k = 0; k < n; k++) begin
      smp_vld = 1'b1; smp_pwr = PW'(p);
      step();
    end
    smp_vld = 1'b0;
  endtask

  task automatic idle(int n);
    smp_vld = 1'b0;
    repeat (n) step();
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R7 f1_n idle", int'(f1_n), 1);
    check("R7 f2_n idle", int'(f2_n), 1);
    check("R7 cf idle", int'(cf), 0);
    check("R7 rev idle", int'(rev_flag), 0);
  endtask

  // Slowest rate, 64 samples per slow event.
  task automatic t_base_rate();
    do_reset(); rate_sel = 2'd0; cal_sel = 1'b0;
    run_const(16, 1024); idle(40);
    check("R1 F1 count", starts[0], 8);
    check("R2 F2 count", starts[1], 8);
    check("R4 CF count lo", starts[2], 64);
    check("R3 F1 nominal width", lastw[0], FW);
    check("R3 CF nominal width", lastw[2], CW);
    check("R8 F1->F2 spacing", tstart[1] - tstart[0], 64);
    check("R5 rev positive", int'(rev_flag), 0);
  endtask

  task automatic t_cal_hi();
    do_reset(); rate_sel = 2'd0; cal_sel = 1'b1;
    run_const(8, 1024); idle(20);
    check("R4 CF count hi", starts[2], 128);
    check("R3 CF shrunk width", lastw[2], 4);
    check("R4 CF first width", firstw[2], CW);
  endtask

  task automatic t_rate_scan();
    for (int rs = 0; rs < 3; rs++) begin
      do_reset(); rate_sel = 2'(rs); cal_sel = 1'b0;
      run_const(16, 512); idle(40);
      check("R1 rate scaling F1", starts[0], 4 << rs);
      check("R1 rate scaling F2", starts[1], 4 << rs);
    end
  endtask

  // Fastest rate: own period 32 < 2*FW, width falls to 16.
  task automatic t_shrink();
    do_reset(); rate_sel = 2'd3; cal_sel = 1'b0;
    run_const(8, 512); idle(40);
    check("R1 F1 count rs3", starts[0], 16);
    check("R3 first pulse full", firstw[0], FW);
    check("R3 F1 half period", lastw[0], 16);
    check("R3 F2 half period", lastw[1], 16);
    check("R8 spacing rs3", tstart[1] - tstart[0], 16);
  endtask

  task automatic t_reverse();
    do_reset(); rate_sel = 2'd0; cal_sel = 1'b0;
    run_const(-16, 1024); idle(40);
    check("R1 magnitude of negative", starts[0], 8);
    check("R5 rev negative", int'(rev_flag), 1);
    run_const(16, 10);
    check("R5 rev held between events", int'(rev_flag), 1);
    run_const(16, 54);
    check("R5 rev cleared at event", int'(rev_flag), 0);
    do_reset();
    run_const(16, 16); run_const(-16, 48);
    check("R5 mixed interval event", int'(!f1_n), 1);
    check("R5 mixed interval negative", int'(rev_flag), 1);
  endtask

  task automatic t_invalid();
    do_reset(); rate_sel = 2'd0; cal_sel = 1'b0;
    smp_vld = 1'b0; smp_pwr = PW'(5000);
    repeat (300) step();
    check("R6 no pulses invalid", starts[0] + starts[1] + starts[2], 0);
    for (int k = 0; k < 1024; k++) begin
      smp_vld = 1'b1; smp_pwr = PW'(16); step();
      smp_vld = 1'b0; smp_pwr = PW'(-2000); step();
    end
    idle(40);
    check("R6 interleaved invalid F1", starts[0], 8);
    check("R6 invalid sign ignored", int'(rev_flag), 0);
  endtask

  // 3000 samples of 10 against 1024: 29 events with carried remainder.
  task automatic t_remainder();
    do_reset(); rate_sel = 2'd0; cal_sel = 1'b0;
    run_const(10, 3000); idle(40);
    check("R1 remainder F1", starts[0], 15);
    check("R1 remainder F2", starts[1], 14);
  endtask

  task automatic t_reset_clears();
    do_reset(); rate_sel = 2'd0; cal_sel = 1'b0;
    run_const(16, 40);
    do_reset();
    run_const(16, 40); idle(30);
    check("R7 bucket cleared", starts[0], 0);
    run_const(16, 24);
    check("R2 F1 low at event edge", int'(f1_n), 0);
    rst_n = 1'b0; step();
    check("R7 F1 idle after reset edge", int'(f1_n), 1);
    check("R7 CF idle after reset edge", int'(cf), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(150000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_base_rate();
    t_cal_hi();
    t_rate_scan();
    t_shrink();
    t_reverse();
    t_invalid();
    t_remainder();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule